// File: doc/BRIEF.md
# Dual-Channel DAC Serial Latch Controller

This block is the digital front end of a two-channel 12-bit converter that is programmed over a three-wire serial link. The link has an active-low chip select, a serial clock and a data line. The block samples the three pins with its own system clock. It assembles a 16-bit command word, most significant bit first. It then routes the 12-bit payload into one of three 12-bit stores: the channel A output latch, the channel B output latch, or a staging latch shared with channel B.

The staging latch lets a single command update both channel outputs at the same moment. Software first loads the staging latch alone. It then issues a channel A write, which moves the staging contents into channel B in the same cycle that channel A takes the new payload.

Every completed command also sets two mode flags. One selects fast or slow output settling and the other powers the converter down. Powering down never alters any latch, so the held codes come back when the device is woken.

Top module: `dual_dac_latch_ctrl`

## Requirements
- R1: A synchronous reset drives code_a, code_b, the staging latch, fast_settle and power_down to zero.
- R2: While cs_n is low, sdi is taken on each rising sclk edge, most significant bit first, into a 16-bit word. Word bit 15 is the A-select bit, bit 14 is the speed bit, bit 13 is the power-down bit, bit 12 is the staging-only bit, and bits 11..0 are the payload. The transfer happens on the 16th rising sclk edge of the frame.
- R3: When bit 15 is 1, code_a takes the payload and code_b takes the staging latch contents in the same cycle. The staging latch is left unchanged, whatever bit 12 holds.
- R4: When bits 15 and 12 are both 0, code_b and the staging latch both take the payload, and code_a is unchanged.
- R5: When bit 15 is 0 and bit 12 is 1, only the staging latch takes the payload. code_a and code_b are unchanged.
- R6: Every transfer loads fast_settle from bit 14, where 1 means fast settling and 0 means slow settling.
- R7: Every transfer loads power_down from bit 13, where 1 means powered down. Entering or leaving power-down changes no latch, so the earlier codes remain on the outputs.
- R8: If cs_n rises before 16 edges have been received, the partial word is dropped and no output changes.
- R9: After the 16th-edge transfer, further sclk edges in the same frame and the following cs_n rise cause no further transfer.
- R10: Each falling edge of cs_n starts a fresh word. No bits from an earlier dropped frame carry over.
- R11: Outputs change exactly two clk cycles after the clk cycle in which the 16th sclk rise is present on the pin. At all other times they hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial bit clock, data taken on its rising edge |
| sdi | input | 1 | Serial data in, MSB first |
| code_a | output | DATA_W | Channel A output latch |
| code_b | output | DATA_W | Channel B output latch |
| fast_settle | output | 1 | 1 selects the fast settling mode |
| power_down | output | 1 | 1 places the converter in power-down |

## Verification
The bench loads the staging latch on its own and then issues an A write. A design that copied the payload rather than the staging contents into channel B, or that cleared or reloaded the staging latch on an A write, shows the wrong code_b on that write or on a repeated A write. Frames cut short, frames padded to 20 edges, and a clean frame that follows a dropped one all check the frame logic. A counter that was not cleared would transfer at the wrong edge, take in stale bits, or fire a second time when cs_n rises. A power-down command sent as a staging-only write, followed by a wake-up command, shows whether power-down touches the latches. Outputs are compared against a model on every clk cycle, so a transfer that lands one cycle early or late is reported.

// File: rtl/dual_dac_latch_ctrl.sv
module dual_dac_latch_ctrl #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b,
  output logic              fast_settle,
  output logic              power_down
);
  localparam int WORD_W = DATA_W + 4;
  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);
  localparam int SEL_A = WORD_W - 1;
  localparam int SPEED = WORD_W - 2;
  localparam int PDOWN = WORD_W - 3;
  localparam int STAGE = WORD_W - 4;

  logic              cs_s, sclk_s, sdi_s, sclk_q;
  logic [WORD_W-2:0] shreg;
  logic [CW-1:0]     cnt;
  logic              done;
  logic [DATA_W-1:0] dbuf;

  logic              sclk_rise, shift_en, xfer;
  logic [WORD_W-1:0] word;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign shift_en  = ~cs_s & sclk_rise & ~done;
  assign xfer      = shift_en & (cnt == LAST);
  assign word      = {shreg, sdi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_s   <= 1'b1;
      sclk_s <= 1'b0;
      sdi_s  <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      cs_s   <= cs_n;
      sclk_s <= sclk;
      sdi_s  <= sdi;
      sclk_q <= sclk_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      cnt   <= '0;
      done  <= 1'b0;
    end else if (cs_s) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (shift_en) begin
      shreg <= word[WORD_W-2:0];
      cnt   <= cnt + 1'b1;
      done  <= xfer;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_a      <= '0;
      code_b      <= '0;
      dbuf        <= '0;
      fast_settle <= 1'b0;
      power_down  <= 1'b0;
    end else if (xfer) begin
      fast_settle <= word[SPEED];
      power_down  <= word[PDOWN];
      if (word[SEL_A]) begin
        code_a <= word[DATA_W-1:0];
        code_b <= dbuf;
      end else begin
        dbuf <= word[DATA_W-1:0];
        if (!word[STAGE]) code_b <= word[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dual_dac_latch_ctrl_chk.sv
module dual_dac_latch_ctrl_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer,
  input logic [DATA_W+3:0] word,
  input logic [DATA_W-1:0] dbuf,
  input logic [DATA_W-1:0] code_a,
  input logic [DATA_W-1:0] code_b,
  input logic              fast_settle,
  input logic              power_down
);
  localparam int WORD_W = DATA_W + 4;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (code_a == '0 && code_b == '0 && dbuf == '0 && !fast_settle && !power_down));

  p_hold_between_r11: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> ($stable(code_a) && $stable(code_b) && $stable(dbuf)
               && $stable(fast_settle) && $stable(power_down)));

  p_write_a_r3: assert property (@(posedge clk) disable iff (rst)
    (xfer && word[WORD_W-1]) |=>
      (code_a == $past(word[DATA_W-1:0]) && code_b == $past(dbuf) && $stable(dbuf)));

  p_write_b_r4: assert property (@(posedge clk) disable iff (rst)
    (xfer && !word[WORD_W-1] && !word[WORD_W-4]) |=>
      (code_b == $past(word[DATA_W-1:0]) && dbuf == $past(word[DATA_W-1:0]) && $stable(code_a)));

  p_stage_only_r5: assert property (@(posedge clk) disable iff (rst)
    (xfer && !word[WORD_W-1] && word[WORD_W-4]) |=>
      (dbuf == $past(word[DATA_W-1:0]) && $stable(code_a) && $stable(code_b)));

  p_speed_flag_r6: assert property (@(posedge clk) disable iff (rst)
    xfer |=> (fast_settle == $past(word[WORD_W-2])));

  p_pdown_flag_r7: assert property (@(posedge clk) disable iff (rst)
    xfer |=> (power_down == $past(word[WORD_W-3])));
endmodule

bind dual_dac_latch_ctrl dual_dac_latch_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .xfer(xfer), .word(word), .dbuf(dbuf),
  .code_a(code_a), .code_b(code_b), .fast_settle(fast_settle), .power_down(power_down)
);

// File: tb/dual_dac_latch_ctrl_bench.sv
module dual_dac_latch_ctrl_bench;
  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [11:0] code_a, code_b;
  logic fast_settle, power_down;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;
  string cur_req = "R1";
  int exp_a = 0, exp_b = 0, exp_stage = 0;
  bit exp_fast = 0, exp_pd = 0;

  always #2 clk = ~clk;

  dual_dac_latch_ctrl u_dual_dac_latch_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .code_a(code_a), .code_b(code_b), .fast_settle(fast_settle), .power_down(power_down)
  );

  task automatic check_val(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", cur_req, what, act, exp, cycles);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check_val("code_a", int'(code_a), exp_a);
    check_val("code_b", int'(code_b), exp_b);
    check_val("fast_settle", int'(fast_settle), int'(exp_fast));
    check_val("power_down", int'(power_down), int'(exp_pd));
  endtask

  task automatic model(input logic [15:0] w);
    exp_fast = w[14];
    exp_pd = w[13];
    if (w[15]) begin
      exp_a = int'(w[11:0]);
      exp_b = exp_stage;
    end else begin
      exp_stage = int'(w[11:0]);
      if (!w[12]) exp_b = int'(w[11:0]);
    end
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input string req);
    cur_req = req;
    cs_n = 1'b0;
    tick(); tick();
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? w[15-i] : ~w[i % 16];
      sclk = 1'b0;
      tick(); tick();
      sclk = 1'b1;
      tick();
      if (i == 15) model(w);
      tick();
    end
    sclk = 1'b0;
    tick();
    cs_n = 1'b1;
    tick(); tick(); tick();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 50000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    tick(); tick();
    send(16'h05A3, 16, "R4 R2");
    send(16'h8123, 16, "R3");
    send(16'h1ABC, 16, "R5");
    send(16'h80FF, 16, "R3 simultaneous");
    send(16'h8777, 16, "R3 stage kept");
    send(16'h9444, 16, "R3 bit12 ignored");
    send(16'h4001, 16, "R6 fast");
    send(16'h0002, 16, "R6 slow");
    send(16'h3999, 16, "R7 enter");
    send(16'h1999, 16, "R7 leave");
    send(16'hFFFF, 9, "R8 partial");
    send(16'h0000, 15, "R8 fifteen");
    send(16'h0C3C, 16, "R10 fresh");
    send(16'h8A5A, 20, "R9 extra edges");
    send(16'hFFFF, 16, "R2 all ones");
    send(16'h2000, 16, "R11 zero code");
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule